// File: doc/BRIEF.md
# Cascaded 16-Line Interrupt Controller

This block joins two eight-line priority interrupt controllers into one sixteen-input controller. The lower unit is the master and the upper unit is the slave. Requests on lines 0 to 7 go to the master and lines 8 to 15 go to the slave. The slave's request output is wired into master line 2. A single CPU interrupt line reports when the master holds a deliverable request. A one-cycle acknowledge strobe makes the pair work out the 8-bit vector. If the master picks its cascade line, the slave joins the acknowledge and supplies the vector. When a unit has nothing to deliver, it reports a spurious vector.

Software reaches the units through a byte-wide I/O port. The command and data ports of the master and the slave differ only in address bit 7. Two edge/level select registers sit at a separate address pair, and address bit 0 picks between them. Each select register accepts writes only through a fixed mask. Each unit has its own initialisation sequence, mask register, end-of-interrupt commands, read-select and poll commands, and an optional nested mode on the master.

Top module: `intc_pair`

## Requirements
- R1: Input line n is handled by unit n/8 (0 = master, 1 = slave) as its local line n mod 8. A delivered vector is {unit base bits 7:3, local line}.
- R2: While the slave has a deliverable request, master line 2 is set as an edge request within one clock, even if the slave line stays high.
- R3: On `ack_req` with a master request pending on a line other than 2, `int_vector` takes {master base, line} at that clock edge and holds until the next `ack_req`. The line's in-service bit is set unless auto-EOI is on. An edge-mode line's request bit is cleared.
- R4: When the master's chosen line is 2, the slave's best request is acknowledged in the same strobe and `int_vector` is {slave base, slave line}.
- R5: When the master chooses line 2 but the slave has nothing deliverable, the vector is {slave base, 7}. Master line 2 still enters service.
- R6: With no deliverable master request, an acknowledge returns {master base, 7} and changes no unit state.
- R7: The select register at 0x4D0 (master) keeps only the bits in 0xF8, and the one at 0x4D1 (slave) keeps only the bits in 0xDE. Masked-out bits read as 0. A set bit makes that line level mode: its request bit follows the input and an acknowledge does not clear it.
- R8: When the master's mode word sets bit 4 (nested mode), master in-service line 2 is ignored in the master's priority comparison. A higher-priority slave request then reaches `cpu_int` while an earlier slave interrupt is in service. Without nested mode it stays blocked.
- R9: Command port 0x20 / data port 0x21 address the master, 0xA0/0xA1 address the slave, and 0x4D0/0x4D1 address the select registers. An access whose `io_size` is not 1 has no effect and reads 0.
- R10: A command-port write with bits 4:3 = 01 and bit 2 = 1 arms a poll. The next command-port read returns 0x80 | line (0x00 if nothing is deliverable). It clears that line's request and in-service bits. A poll on the slave also clears master line 2's request and in-service bits.
- R11: `cpu_int` is high exactly when the master has an unmasked request whose line number is lower than its highest-priority in-service line. It is 0 after reset.
- R12: Line 0 has the highest priority. Command code 001 in bits 7:5 clears the highest-priority in-service bit. Code 011 clears the in-service bit named in bits 2:0.
- R13: A command-port write with bit 4 set clears mask, request and in-service bits and starts initialisation. The next data-port writes give the base (bits 7:3), a cascade word, and, if bit 0 of the first word was set, a mode word (bit 4 nested, bit 1 auto-EOI). After that, data-port writes set the mask. Command bits 4:3 = 01 with bit 1 set select the command-port read: ISR if bit 0 is 1, IRR if 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 16 | Interrupt request inputs |
| io_addr | input | 16 | I/O register address |
| io_size | input | 3 | Access size in bytes; only 1 is accepted |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe (poll side effects at the clock edge) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from the current state |
| ack_req | input | 1 | One-cycle interrupt acknowledge request |
| cpu_int | output | 1 | Interrupt request to the processor |
| int_vector | output | 8 | Vector latched by the last acknowledge |

## Verification
The bench builds the block with its default parameters. The port pair 0x20/0xA0 differs only in bit 7, and the select registers sit at 0x4D0/0x4D1. The master mask 0xF8 and slave mask 0xDE keep master line 2 and slave lines 0 and 5 in edge mode, and the cascade sits on line 2. With these values the bench can reach spurious vectors from both units, nesting of slave interrupts with and without nested mode, and the poll path clearing the master's cascade bits. It can also show masked select bits reading as zero while a legal select bit makes slave line 1 level-sensitive.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int UNIT_LINES = 8;
  localparam int UNIT_IW    = 3;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_BASE,
    ST_CASC,
    ST_MODE
  } init_state_e;

  // highest-priority (lowest-numbered) set bit, UNIT_LINES when none
  function automatic logic [UNIT_IW:0] first_line(input logic [UNIT_LINES-1:0] m);
    first_line = (UNIT_IW+1)'(UNIT_LINES);
    for (int i = UNIT_LINES - 1; i >= 0; i--) begin
      if (m[i]) first_line = (UNIT_IW+1)'(i);
    end
  endfunction

  function automatic logic [UNIT_LINES-1:0] line_bit(input logic [UNIT_IW-1:0] idx);
    line_bit      = '0;
    line_bit[idx] = 1'b1;
  endfunction

endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 16'h0020,
  parameter logic [ADDR_W-1:0] ELCR_BASE = 16'h04D0
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [2:0]        io_size,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [1:0]        wr_even,
  output logic [1:0]        wr_odd,
  output logic [1:0]        wr_elcr,
  output logic [1:0]        rd_even,
  output logic              rd_ctrl,
  output logic              rd_elcr,
  output logic              sel_unit,
  output logic              sel_a0
);

  logic byte_ok, ctrl_hit, elcr_hit;

  always_comb begin
    byte_ok  = (io_size == 3'd1);
    ctrl_hit = byte_ok && (io_addr[ADDR_W-1:8] == CTRL_BASE[ADDR_W-1:8])
                       && (io_addr[6:1] == CTRL_BASE[6:1]);
    elcr_hit = byte_ok && (io_addr[ADDR_W-1:1] == ELCR_BASE[ADDR_W-1:1]);
    sel_unit = io_addr[7];
    sel_a0   = io_addr[0];
    rd_ctrl  = io_rd && ctrl_hit;
    rd_elcr  = io_rd && elcr_hit;
  end

  for (genvar g = 0; g < 2; g++) begin : g_sel
    always_comb begin
      wr_even[g] = io_wr && ctrl_hit && (sel_unit == 1'(g)) && !sel_a0;
      wr_odd[g]  = io_wr && ctrl_hit && (sel_unit == 1'(g)) &&  sel_a0;
      rd_even[g] = io_rd && ctrl_hit && (sel_unit == 1'(g)) && !sel_a0;
      wr_elcr[g] = io_wr && elcr_hit && (sel_a0 == 1'(g));
    end
  end

endmodule

// File: rtl/intc_unit.sv
module intc_unit
  import intc_pkg::*;
#(
  parameter bit                    IS_MASTER = 1'b1,
  parameter int                    CAS_LINE  = 2,
  parameter logic [UNIT_LINES-1:0] ELCR_MASK = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [UNIT_LINES-1:0] lines_in,
  input  logic [UNIT_LINES-1:0] force_set,
  input  logic [UNIT_LINES-1:0] ext_clr,
  input  logic                  wr_even,
  input  logic                  wr_odd,
  input  logic                  wr_elcr,
  input  logic                  rd_even,
  input  logic [7:0]            wdata,
  input  logic                  ack_en,
  input  logic [UNIT_IW-1:0]    ack_idx,
  output logic                  int_out,
  output logic                  poll_hit,
  output logic [UNIT_IW-1:0]    best_idx,
  output logic [4:0]            vbase,
  output logic [7:0]            rd_even_data,
  output logic [7:0]            rd_odd_data,
  output logic [UNIT_LINES-1:0] elcr_out
);

  localparam logic [UNIT_LINES-1:0] CAS_BIT = line_bit(UNIT_IW'(CAS_LINE));

  logic [UNIT_LINES-1:0] irr_q, irr_d, isr_q, isr_d, imr_q, imr_d;
  logic [UNIT_LINES-1:0] last_q, elcr_q, elcr_d;
  logic [4:0]            base_q, base_d;
  init_state_e           st_q, st_d;
  logic                  need4_q, need4_d, rsel_q, rsel_d, poll_q, poll_d;
  logic                  aeoi_q, aeoi_d, nest_q, nest_d;
  logic                  icw1, ocw2, ocw3, cfg_en;
  logic [UNIT_IW:0]      best, cur, isr_top;
  logic [UNIT_LINES-1:0] req, cur_mask, rise, ack_bit, poll_bit, eoi_bit;

  // priority resolution
  always_comb begin
    req      = irr_q & ~imr_q;
    best     = first_line(req);
    cur_mask = isr_q & ~((IS_MASTER && nest_q) ? CAS_BIT : '0);
    cur      = first_line(cur_mask);
    isr_top  = first_line(isr_q);
    int_out  = (best < cur);
    best_idx = best[UNIT_IW-1:0];
    poll_hit = rd_even && poll_q && int_out;
    vbase    = base_q;
    elcr_out = elcr_q;
    rd_odd_data  = imr_q;
    if (poll_q)      rd_even_data = int_out ? {5'b10000, best[UNIT_IW-1:0]} : 8'h00;
    else if (rsel_q) rd_even_data = isr_q;
    else             rd_even_data = irr_q;
  end

  // next state
  always_comb begin
    icw1     = wr_even &&  wdata[4];
    ocw3     = wr_even && !wdata[4] &&  wdata[3];
    ocw2     = wr_even && !wdata[4] && !wdata[3];
    cfg_en   = wr_even || wr_odd || wr_elcr || rd_even;
    rise     = lines_in & ~last_q;
    ack_bit  = ack_en   ? line_bit(ack_idx) : '0;
    poll_bit = poll_hit ? line_bit(best[UNIT_IW-1:0]) : '0;
    eoi_bit  = '0;
    if (ocw2) begin
      case (wdata[7:5])
        3'b001:  if (isr_q != '0) eoi_bit = line_bit(isr_top[UNIT_IW-1:0]);
        3'b011:  eoi_bit = line_bit(wdata[2:0]);
        default: eoi_bit = '0;
      endcase
    end
    isr_d  = (isr_q & ~(eoi_bit | poll_bit | ext_clr)) | (aeoi_q ? '0 : ack_bit);
    irr_d  = (elcr_q & lines_in)
           | (~elcr_q & (irr_q | rise | force_set)
                      & ~((ack_bit & ~elcr_q) | poll_bit | ext_clr));
    imr_d  = imr_q;   base_d  = base_q;  st_d   = st_q;   need4_d = need4_q;
    rsel_d = rsel_q;  poll_d  = poll_q;  aeoi_d = aeoi_q; nest_d  = nest_q;
    elcr_d = elcr_q;
    if (wr_elcr) elcr_d = wdata & ELCR_MASK;
    if (rd_even && poll_q) poll_d = 1'b0;
    if (ocw3) begin
      if (wdata[2]) poll_d = 1'b1;
      if (wdata[1]) rsel_d = wdata[0];
    end
    if (wr_odd) begin
      case (st_q)
        ST_RUN:  imr_d = wdata;
        ST_BASE: begin base_d = wdata[7:3]; st_d = ST_CASC; end
        ST_CASC: st_d = need4_q ? ST_MODE : ST_RUN;
        default: begin nest_d = wdata[4]; aeoi_d = wdata[1]; st_d = ST_RUN; end
      endcase
    end
    if (icw1) begin
      irr_d  = '0;   isr_d  = '0;   imr_d  = '0;
      rsel_d = 1'b0; poll_d = 1'b0; aeoi_d = 1'b0; nest_d = 1'b0;
      need4_d = wdata[0];
      st_d    = ST_BASE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      last_q <= '0;
    end else begin
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      last_q <= (wr_even && wdata[4]) ? '0 : lines_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q <= '0;  elcr_q <= '0; base_q <= '0; st_q <= ST_RUN;
      need4_q <= 1'b0; rsel_q <= 1'b0; poll_q <= 1'b0;
      aeoi_q  <= 1'b0; nest_q <= 1'b0;
    end else if (cfg_en) begin
      imr_q <= imr_d;  elcr_q <= elcr_d; base_q <= base_d; st_q <= st_d;
      need4_q <= need4_d; rsel_q <= rsel_d; poll_q <= poll_d;
      aeoi_q  <= aeoi_d;  nest_q <= nest_d;
    end
  end

  // R3
  isr_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !aeoi_q && !wr_even && !rd_even && (ext_clr == '0)) |=> isr_q[$past(ack_idx)]);

  // R3
  edge_irr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !elcr_q[ack_idx] && !wr_elcr) |=> !irr_q[$past(ack_idx)]);

  // R7
  elcr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_elcr |=> ((elcr_q & ~ELCR_MASK) == '0));

endmodule

// File: rtl/intc_ackpath.sv
module intc_ackpath
  import intc_pkg::*;
#(
  parameter int CAS_LINE = 2
) (
  input  logic               ack_req,
  input  logic               m_int,
  input  logic [UNIT_IW-1:0] m_idx,
  input  logic [4:0]         m_base,
  input  logic               s_int,
  input  logic [UNIT_IW-1:0] s_idx,
  input  logic [4:0]         s_base,
  output logic               m_ack,
  output logic               s_ack,
  output logic [7:0]         vec
);

  localparam logic [UNIT_IW-1:0] CAS_IDX = UNIT_IW'(CAS_LINE);
  localparam logic [UNIT_IW-1:0] SPUR    = UNIT_IW'(UNIT_LINES - 1);

  logic via_slave;

  always_comb begin
    via_slave = m_int && (m_idx == CAS_IDX);
    m_ack     = ack_req && m_int;
    s_ack     = ack_req && via_slave && s_int;
    if (!m_int)         vec = {m_base, SPUR};
    else if (!via_slave) vec = {m_base, m_idx};
    else if (s_int)      vec = {s_base, s_idx};
    else                 vec = {s_base, SPUR};
  end

endmodule

// File: rtl/intc_pair.sv
module intc_pair
  import intc_pkg::*;
#(
  parameter int                  ADDR_W      = 16,
  parameter logic [ADDR_W-1:0]   CTRL_BASE   = 16'h0020,
  parameter logic [ADDR_W-1:0]   ELCR_BASE   = 16'h04D0,
  parameter logic [UNIT_LINES-1:0] M_ELCR_MASK = 8'hF8,
  parameter logic [UNIT_LINES-1:0] S_ELCR_MASK = 8'hDE,
  parameter int                  CAS_LINE    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       irq_lines,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [2:0]        io_size,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              ack_req,
  output logic              cpu_int,
  output logic [7:0]        int_vector
);

  localparam int NUM_UNITS = 2;
  localparam logic [UNIT_LINES-1:0] CAS_BIT = line_bit(UNIT_IW'(CAS_LINE));

  logic rst_meta, rst_q;
  logic [1:0] wr_even, wr_odd, wr_elcr, rd_even;
  logic       rd_ctrl, rd_elcr, sel_unit, sel_a0;
  logic [NUM_UNITS-1:0]                 int_v, poll_v, ack_v;
  logic [NUM_UNITS-1:0][UNIT_IW-1:0]    best_v;
  logic [NUM_UNITS-1:0][4:0]            base_v;
  logic [NUM_UNITS-1:0][UNIT_LINES-1:0] force_v, clr_v, even_v, odd_v, elcr_v;
  logic [7:0] vec_c;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  intc_decode #(.ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE), .ELCR_BASE(ELCR_BASE)) u_dec (
    .io_addr(io_addr), .io_size(io_size), .io_wr(io_wr), .io_rd(io_rd),
    .wr_even(wr_even), .wr_odd(wr_odd), .wr_elcr(wr_elcr), .rd_even(rd_even),
    .rd_ctrl(rd_ctrl), .rd_elcr(rd_elcr), .sel_unit(sel_unit), .sel_a0(sel_a0)
  );

  // cascade wiring: slave request sets master cascade line, slave poll clears it
  always_comb begin
    force_v[0] = int_v[1]  ? CAS_BIT : '0;
    force_v[1] = '0;
    clr_v[0]   = poll_v[1] ? CAS_BIT : '0;
    clr_v[1]   = '0;
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    intc_unit #(
      .IS_MASTER(g == 0),
      .CAS_LINE (CAS_LINE),
      .ELCR_MASK((g == 0) ? M_ELCR_MASK : S_ELCR_MASK)
    ) u_unit (
      .clk(clk), .rst_n(rst_q),
      .lines_in(irq_lines[g*UNIT_LINES +: UNIT_LINES]),
      .force_set(force_v[g]), .ext_clr(clr_v[g]),
      .wr_even(wr_even[g]), .wr_odd(wr_odd[g]), .wr_elcr(wr_elcr[g]),
      .rd_even(rd_even[g]), .wdata(io_wdata),
      .ack_en(ack_v[g]), .ack_idx(best_v[g]),
      .int_out(int_v[g]), .poll_hit(poll_v[g]), .best_idx(best_v[g]),
      .vbase(base_v[g]), .rd_even_data(even_v[g]), .rd_odd_data(odd_v[g]),
      .elcr_out(elcr_v[g])
    );
  end

  intc_ackpath #(.CAS_LINE(CAS_LINE)) u_ack (
    .ack_req(ack_req),
    .m_int(int_v[0]), .m_idx(best_v[0]), .m_base(base_v[0]),
    .s_int(int_v[1]), .s_idx(best_v[1]), .s_base(base_v[1]),
    .m_ack(ack_v[0]), .s_ack(ack_v[1]), .vec(vec_c)
  );

  always_comb begin
    cpu_int = int_v[0];
    if (rd_ctrl)      io_rdata = sel_a0 ? odd_v[sel_unit] : even_v[sel_unit];
    else if (rd_elcr) io_rdata = elcr_v[sel_a0];
    else              io_rdata = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)       int_vector <= 8'h00;
    else if (ack_req) int_vector <= vec_c;
  end

  // R3
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !ack_req |=> $stable(int_vector));

  // R4
  slave_vec_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ack_v[1] |=> (int_vector[7:3] == $past(base_v[1])));

endmodule

// File: tb/tb_intc_pair.sv
module tb_intc_pair;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_lines;
  logic [15:0] io_addr;
  logic [2:0]  io_size;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        ack_req;
  logic        cpu_int;
  logic [7:0]  int_vector;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [7:0] MB = 8'h08;
  localparam logic [7:0] SB = 8'h70;

  // bench model of both units (random phase, edge mode only)
  logic [7:0] m_irr, m_isr, m_imr, s_irr, s_isr, s_imr;
  bit         m_nest;

  always #2 clk = ~clk;

  intc_pair dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .io_addr(io_addr),
    .io_size(io_size), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .ack_req(ack_req), .cpu_int(cpu_int),
    .int_vector(int_vector)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d, input logic [2:0] sz);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_size = sz; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_size = 3'd1;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_size = 3'd1; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk);
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
    v = int_vector;
    settle();
  endtask

  task automatic pulse(input logic [15:0] p);
    @(negedge clk);
    irq_lines = p;
    repeat (2) @(negedge clk);
    irq_lines = 16'h0;
    settle();
  endtask

  task automatic init_unit(input logic [15:0] cmd, input logic [7:0] base,
                           input logic [7:0] cas, input logic [7:0] mode);
    io_write(cmd, 8'h11, 3'd1);
    io_write(cmd | 16'h1, base, 3'd1);
    io_write(cmd | 16'h1, cas, 3'd1);
    io_write(cmd | 16'h1, mode, 3'd1);
    settle();
  endtask

  function automatic int lo(input logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return 8;
  endfunction

  function automatic int pick(input logic [7:0] irr, input logic [7:0] imr,
                              input logic [7:0] isr, input bit skip_cas);
    int b, c;
    b = lo(irr & ~imr);
    c = lo(skip_cas ? (isr & 8'hFB) : isr);
    return (b < c) ? b : -1;
  endfunction

  task automatic model_cascade();
    if (pick(s_irr, s_imr, s_isr, 1'b0) >= 0) m_irr[2] = 1'b1;
  endtask

  // expected vector per R3..R6; kind: 0 master line, 1 slave line, 2 slave spurious, 3 master spurious
  task automatic model_ack(output logic [7:0] v, output int kind);
    int mi, si;
    mi = pick(m_irr, m_imr, m_isr, m_nest);
    if (mi < 0) begin
      v = MB | 8'd7; kind = 3;
    end else begin
      m_isr[mi] = 1'b1; m_irr[mi] = 1'b0;
      if (mi == 2) begin
        si = pick(s_irr, s_imr, s_isr, 1'b0);
        if (si >= 0) begin
          s_isr[si] = 1'b1; s_irr[si] = 1'b0;
          v = SB | 8'(si); kind = 1;
        end else begin
          v = SB | 8'd7; kind = 2;
        end
      end else begin
        v = MB | 8'(mi); kind = 0;
      end
    end
    model_cascade();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, v, ev;
    int kind, seed;
    rst_n = 1'b0; irq_lines = 16'h0; io_addr = 16'h0; io_size = 3'd1;
    io_wr = 1'b0; io_rd = 1'b0; io_wdata = 8'h0; ack_req = 1'b0;
    seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R11: reset state
    check("R11 reset cpu_int", {7'b0, cpu_int}, 8'h00);
    check("R3 reset vector", int_vector, 8'h00);

    // R7: select register masks
    io_write(16'h04D0, 8'hFF, 3'd1);
    io_read(16'h04D0, r); check("R7 master select mask", r, 8'hF8);
    io_write(16'h04D1, 8'hFF, 3'd1);
    io_read(16'h04D1, r); check("R7 slave select mask", r, 8'hDE);
    io_write(16'h04D0, 8'h00, 3'd1);
    io_write(16'h04D1, 8'h00, 3'd1);

    // R13 / R9: init, then mask writes, wrong-size write ignored
    init_unit(16'h00A0, SB, 8'h02, 8'h01);
    init_unit(16'h0020, MB, 8'h04, 8'h01);
    io_write(16'h0021, 8'h55, 3'd1);
    io_write(16'h0021, 8'hAA, 3'd2);
    io_read(16'h0021, r); check("R9 size-2 write ignored", r, 8'h55);
    io_read(16'h00A1, r); check("R13 slave mask cleared by init", r, 8'h00);
    io_write(16'h0021, 8'h00, 3'd1);

    // R6: spurious master
    do_ack(v); check("R6 master spurious vector", v, MB | 8'd7);
    check("R11 idle cpu_int", {7'b0, cpu_int}, 8'h00);

    // R1/R4/R2: line 11 through the cascade
    pulse(16'h0800);
    check("R2 cascade raises cpu_int", {7'b0, cpu_int}, 8'h01);
    do_ack(v); check("R4 slave vector line 11", v, 8'h73);
    io_write(16'h00A0, 8'h20, 3'd1);
    io_write(16'h0020, 8'h20, 3'd1);
    settle();

    // R5: slave request withdrawn by its mask
    pulse(16'h1000);
    io_write(16'h00A1, 8'h10, 3'd1);
    settle();
    do_ack(v); check("R5 slave spurious vector", v, SB | 8'd7);
    io_write(16'h0020, 8'h0B, 3'd1);
    io_read(16'h0020, r); check("R5 master line 2 in service", r, 8'h04);
    io_write(16'h0020, 8'h20, 3'd1);
    io_write(16'h00A1, 8'h00, 3'd1);
    settle();
    do_ack(v); check("R4 unmasked slave line 12", v, 8'h74);
    io_write(16'h00A0, 8'h20, 3'd1);
    io_write(16'h0020, 8'h20, 3'd1);
    settle();

    // R7: level mode on slave line 1 (input 9)
    io_write(16'h04D1, 8'h02, 3'd1);
    @(negedge clk); irq_lines = 16'h0200;
    settle();
    do_ack(v); check("R7 level line vector", v, 8'h71);
    io_write(16'h00A0, 8'h0A, 3'd1);
    io_read(16'h00A0, r); check("R7 level request kept after ack", r, 8'h02);
    @(negedge clk); irq_lines = 16'h0000;
    settle();
    io_read(16'h00A0, r); check("R7 level request follows input", r, 8'h00);
    io_write(16'h00A0, 8'h20, 3'd1);
    io_write(16'h0020, 8'h20, 3'd1);
    io_write(16'h04D1, 8'h00, 3'd1);
    settle();

    // R10: poll on slave clears master cascade bits
    pulse(16'h2000);
    io_write(16'h00A0, 8'h0C, 3'd1);
    io_read(16'h00A0, r); check("R10 slave poll result", r, 8'h85);
    settle();
    io_write(16'h0020, 8'h0A, 3'd1);
    io_read(16'h0020, r); check("R10 master line 2 request cleared", r, 8'h00);
    io_write(16'h00A0, 8'h0C, 3'd1);
    io_read(16'h00A0, r); check("R10 empty poll", r, 8'h00);

    // R12: priority and specific EOI
    pulse(16'h0012);
    do_ack(v); check("R12 line 1 before line 4", v, 8'h09);
    check("R12 lower line blocked", {7'b0, cpu_int}, 8'h00);
    io_write(16'h0020, 8'h61, 3'd1);
    settle();
    check("R12 specific EOI releases", {7'b0, cpu_int}, 8'h01);
    do_ack(v); check("R12 line 4 vector", v, 8'h0C);
    io_write(16'h0020, 8'h20, 3'd1);
    settle();

    // R8: nested mode on master
    init_unit(16'h00A0, SB, 8'h02, 8'h01);
    init_unit(16'h0020, MB, 8'h04, 8'h11);
    pulse(16'h0800);
    do_ack(v); check("R8 first slave vector", v, 8'h73);
    pulse(16'h0200);
    check("R8 nested cpu_int", {7'b0, cpu_int}, 8'h01);
    do_ack(v); check("R8 nested slave vector", v, 8'h71);
    init_unit(16'h00A0, SB, 8'h02, 8'h01);
    init_unit(16'h0020, MB, 8'h04, 8'h01);
    pulse(16'h0800);
    do_ack(v); check("R8 plain first vector", v, 8'h73);
    pulse(16'h0200);
    check("R8 plain mode blocks", {7'b0, cpu_int}, 8'h00);

    // random phase checked against the bench model
    for (int t = 0; t < 40; t++) begin
      logic [15:0] p;
      m_nest = 1'($urandom % 2);
      init_unit(16'h00A0, SB, 8'h02, 8'h01);
      init_unit(16'h0020, MB, 8'h04, m_nest ? 8'h11 : 8'h01);
      m_irr = 0; m_isr = 0; s_irr = 0; s_isr = 0;
      m_imr = 8'($urandom & $urandom & $urandom);
      s_imr = 8'($urandom & $urandom & $urandom);
      io_write(16'h0021, m_imr, 3'd1);
      io_write(16'h00A1, s_imr, 3'd1);
      settle();
      p = 16'($urandom);
      pulse(p);
      m_irr = m_irr | p[7:0];
      s_irr = s_irr | p[15:8];
      model_cascade();
      check("R11 random cpu_int", {7'b0, cpu_int},
            {7'b0, pick(m_irr, m_imr, m_isr, m_nest) >= 0});
      for (int k = 0; k < 4; k++) begin
        model_ack(ev, kind);
        do_ack(v);
        check("R1 R3 R4 random vector", v, ev);
        if ($urandom % 2 == 1) begin
          if (kind == 1) begin
            io_write(16'h00A0, 8'h20, 3'd1);
            s_isr[lo(s_isr)] = 1'b0;
            model_cascade();
          end
          if (kind != 3) begin
            io_write(16'h0020, 8'h20, 3'd1);
            m_isr[lo(m_isr)] = 1'b0;
            model_cascade();
          end
          settle();
        end
        check("R11 random cpu_int after ack", {7'b0, cpu_int},
              {7'b0, pick(m_irr, m_imr, m_isr, m_nest) >= 0});
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule